// File: doc/BRIEF.md
# Shadow-Latched Millisecond Real-Time Clock

This block keeps wall time as a count of whole seconds plus a count of milliseconds within the current second. Both counts advance on a one-cycle tick strobe that arrives once per millisecond. The millisecond count runs through one full second and then carries into the seconds count. Software reaches the block through a small read/write register port. Each read returns its data one cycle after the request.

Seconds and milliseconds live in separate registers, so a software read of both could straddle a carry and return a torn time. To prevent this, any read of the millisecond register also copies the live seconds value into a shadow register on the same clock edge. The recommended sequence is to read milliseconds, then read the shadow seconds, and compute seconds times one thousand plus milliseconds. The two values always belong to the same instant. A write to the live seconds register presets the time and restarts the sub-second count.

Top module: `rtc_shadow_clock`

## Requirements
- R1: After reset the live seconds, milliseconds and shadow seconds are all zero, and `rsp_valid` is low while reset is held.
- R2: Each cycle with `tick` high advances the millisecond count by one. Without a tick, the count holds.
- R3: A tick while milliseconds equal 999 sets milliseconds to 0 and adds one to the live seconds.
- R4: A read request (`req_valid` high, `req_write` low) raises `rsp_valid` for exactly the next cycle, with `rsp_rdata` holding the value as it was in the request cycle. A read at offset 0x10 returns the milliseconds.
- R5: A read at offset 0x10 copies the live seconds, as they were in that request cycle, into the shadow register. A later read at offset 0x0C returns that copy.
- R6: Only a read at offset 0x10 changes the shadow register. Ticks, carries, presets, other reads and all writes leave it as it is.
- R7: A read at offset 0x08 returns the live seconds.
- R8: A write at offset 0x08 loads `req_wdata` into the live seconds and clears milliseconds to 0. If a tick arrives in the same cycle, the write takes precedence.
- R9: Writes to any offset other than 0x08 have no effect. Reads of any offset other than 0x08, 0x0C and 0x10 return zero.
- R10: The live seconds wrap from all ones to zero on a millisecond carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe, once per millisecond |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (8) | Byte offset of the register |
| req_wdata | input | DATA_W (32) | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | DATA_W (32) | Read data |

## Verification
The assertions rely on `tick` being a single-cycle strobe sampled on the clock, so that one high cycle means exactly one millisecond. They also rely on requests being single-cycle, with one request at most per cycle. The response checks assume that a read is never issued while reset is active. The stimulus drives every input on the falling clock edge and issues at most one access per cycle. It places ticks in the same cycle as reads and presets to cover the priority and coherence corners, including a carry that happens between the millisecond read and the shadow read.

// File: rtl/rtc_shadow_pkg.sv
package rtc_shadow_pkg;
   localparam int unsigned OFS_SEC_LIVE   = 8'h08;
   localparam int unsigned OFS_SEC_SHADOW = 8'h0C;
   localparam int unsigned OFS_MSEC       = 8'h10;

   typedef enum logic [1:0] {
      SEL_NONE   = 2'd0,
      SEL_LIVE   = 2'd1,
      SEL_SHADOW = 2'd2,
      SEL_MSEC   = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/rtc_subsec_counter.sv
module rtc_subsec_counter #(
   parameter int unsigned MODULUS = 1000,
   localparam int unsigned CW = (MODULUS > 1) ? $clog2(MODULUS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  logic          clear,
   output logic [CW-1:0] count,
   output logic          carry
);
   logic at_top;

   initial begin
      assert (MODULUS >= 2) else $error("MODULUS must be at least 2");
   end

   generate
      if ((MODULUS & (MODULUS - 1)) == 0) begin : g_pow2
         assign at_top = &count;
      end else begin : g_cmp
         assign at_top = (count == CW'(MODULUS - 1));
      end
   endgenerate

   assign carry = step && at_top && !clear;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         count <= '0;
      end else if (step) begin
         count <= at_top ? '0 : count + 1'b1;
      end
   end

   a_r2_step : assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clear && count != CW'(MODULUS - 1)) |=> count == $past(count) + 1'b1);
   a_r2_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !clear) |=> $stable(count));
   a_r3_in_range : assert property (@(posedge clk) disable iff (!rst_n)
      count < CW'(MODULUS));
   a_r8_clear : assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> count == '0);
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
   parameter int unsigned SEC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             load,
   input  logic [SEC_W-1:0] load_val,
   output logic [SEC_W-1:0] seconds
);
   initial begin
      assert (SEC_W >= 8) else $error("SEC_W too small");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seconds <= '0;
      end else if (load) begin
         seconds <= load_val;
      end else if (inc) begin
         seconds <= seconds + 1'b1;
      end
   end

   a_r3_carry_adds_one : assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !load) |=> seconds == $past(seconds) + 1'b1);
   a_r3_no_spurious : assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !load) |=> $stable(seconds));
   a_r8_preset : assert property (@(posedge clk) disable iff (!rst_n)
      load |=> seconds == $past(load_val));
endmodule

// File: rtl/rtc_regport.sv
module rtc_regport
   import rtc_shadow_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned SEC_W  = 32,
   parameter int unsigned MS_W   = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [SEC_W-1:0]  live_sec,
   input  logic [MS_W-1:0]   live_ms,
   output logic              preset,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata
);
   reg_sel_e         sel;
   logic             rd;
   logic [SEC_W-1:0] shadow_sec;
   logic [DATA_W-1:0] rd_mux;

   initial begin
      assert (SEC_W <= DATA_W) else $error("seconds wider than data");
      assert (MS_W <= DATA_W) else $error("milliseconds wider than data");
      assert (ADDR_W >= 5) else $error("address too narrow for map");
   end

   always_comb begin
      if (req_addr == ADDR_W'(OFS_SEC_LIVE))        sel = SEL_LIVE;
      else if (req_addr == ADDR_W'(OFS_SEC_SHADOW)) sel = SEL_SHADOW;
      else if (req_addr == ADDR_W'(OFS_MSEC))       sel = SEL_MSEC;
      else                                          sel = SEL_NONE;
   end

   assign rd     = req_valid && !req_write;
   assign preset = req_valid && req_write && (sel == SEL_LIVE);

   always_comb begin
      case (sel)
         SEL_LIVE:   rd_mux = DATA_W'(live_sec);
         SEL_SHADOW: rd_mux = DATA_W'(shadow_sec);
         SEL_MSEC:   rd_mux = DATA_W'(live_ms);
         default:    rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow_sec <= '0;
         rsp_valid  <= 1'b0;
         rsp_rdata  <= '0;
      end else begin
         rsp_valid <= rd;
         if (rd) rsp_rdata <= rd_mux;
         if (rd && sel == SEL_MSEC) shadow_sec <= live_sec;
      end
   end

   a_r4_rsp_follows : assert property (@(posedge clk) disable iff (!rst_n)
      rd |=> rsp_valid);
   a_r4_rsp_single : assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> !rsp_valid);
   a_r5_capture : assert property (@(posedge clk) disable iff (!rst_n)
      (rd && sel == SEL_MSEC) |=> shadow_sec == $past(live_sec));
   a_r6_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !(rd && sel == SEL_MSEC) |=> $stable(shadow_sec));
endmodule

// File: rtl/rtc_shadow_clock.sv
module rtc_shadow_clock #(
   parameter int unsigned ADDR_W        = 8,
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned SEC_W         = 32,
   parameter int unsigned TICKS_PER_SEC = 1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata
);
   localparam int unsigned MS_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;

   logic             preset;
   logic             ms_carry;
   logic [MS_W-1:0]  ms_count;
   logic [SEC_W-1:0] sec_count;

   initial begin
      assert (SEC_W == DATA_W) else $error("seconds must fill a data word");
   end

   rtc_subsec_counter #(.MODULUS(TICKS_PER_SEC)) u_subsec (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (tick),
      .clear (preset),
      .count (ms_count),
      .carry (ms_carry)
   );

   rtc_sec_counter #(.SEC_W(SEC_W)) u_sec (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc      (ms_carry),
      .load     (preset),
      .load_val (req_wdata),
      .seconds  (sec_count)
   );

   rtc_regport #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .SEC_W  (SEC_W),
      .MS_W   (MS_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .live_sec  (sec_count),
      .live_ms   (ms_count),
      .preset    (preset),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata)
   );

   a_r10_wrap : assert property (@(posedge clk) disable iff (!rst_n)
      (ms_carry && !preset && sec_count == '1) |=> sec_count == '0);
endmodule

// File: tb/rtc_shadow_clock_test.sv
module rtc_shadow_clock_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [7:0]  req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [31:0] exp_q[$];
   string       tag_q[$];

   int unsigned m_ms = 0;
   logic [31:0] m_sec = '0;
   logic [31:0] m_shadow = '0;

   always #2 clk = ~clk;

   rtc_shadow_clock uut (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   // one cycle: inputs set at the falling edge, model advanced across the rising edge
   task automatic cyc(input bit t, input bit v, input bit w, input logic [7:0] a,
                      input logic [31:0] d, input string tag);
      tick = t; req_valid = v; req_write = w; req_addr = a; req_wdata = d;
      if (v && !w) begin
         logic [31:0] e;
         case (a)
            8'h08:   e = m_sec;
            8'h0C:   e = m_shadow;
            8'h10:   e = 32'(m_ms);
            default: e = '0;
         endcase
         exp_q.push_back(e);
         tag_q.push_back(tag);
         if (a == 8'h10) m_shadow = m_sec;
      end
      if (v && w && a == 8'h08) begin
         m_sec = d; m_ms = 0;
      end else if (t) begin
         if (m_ms == 999) begin m_ms = 0; m_sec = m_sec + 1; end
         else m_ms = m_ms + 1;
      end
      @(posedge clk);
      @(negedge clk);
      tick = 1'b0; req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input string tag);
      cyc(1'b0, 1'b1, 1'b0, a, '0, tag);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, '0, '0, "");
   endtask

   // monitor: scoreboard compare
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R4 unexpected response", rsp_rdata, '0);
         end else begin
            logic [31:0] e;
            string tg;
            e = exp_q.pop_front();
            tg = tag_q.pop_front();
            check(rsp_rdata === e, tg, rsp_rdata, e);
         end
      end
   end

   initial begin
      #400000;
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog expired actual=0x0 expected=0x1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(rsp_valid === 1'b0, "R1 rsp_valid low in reset", {31'b0, rsp_valid}, '0);
      rst_n = 1'b1;
      rd(8'h10, "R1 reset ms");
      rd(8'h08, "R1 reset live sec");
      rd(8'h0C, "R1 reset shadow");

      ticks(5);
      rd(8'h10, "R2 ms after 5 ticks");
      cyc(1'b0, 1'b0, 1'b0, '0, '0, "");
      cyc(1'b0, 1'b0, 1'b0, '0, '0, "");
      rd(8'h10, "R2 ms holds without tick");
      cyc(1'b1, 1'b1, 1'b0, 8'h10, '0, "R4 read with same-cycle tick");

      ticks(993);
      rd(8'h10, "R3 ms at 999");
      rd(8'h08, "R7 live sec before carry");
      cyc(1'b1, 1'b1, 1'b0, 8'h10, '0, "R3 ms read in carry cycle");
      rd(8'h0C, "R5 shadow holds pre-carry sec");
      rd(8'h08, "R3 sec after carry");
      rd(8'h10, "R3 ms after carry");
      rd(8'h0C, "R5 shadow after fresh ms read");

      cyc(1'b0, 1'b1, 1'b1, 8'h08, 32'h0000_1234, "");
      rd(8'h0C, "R6 shadow unchanged by preset");
      rd(8'h08, "R8 preset value");
      rd(8'h10, "R8 ms cleared by preset");
      ticks(7);
      cyc(1'b1, 1'b1, 1'b1, 8'h08, 32'h0000_0055, "");
      rd(8'h10, "R8 preset beats tick");
      rd(8'h08, "R8 preset with tick sec");

      ticks(3);
      rd(8'h10, "R5 capture before ignored writes");
      cyc(1'b0, 1'b1, 1'b1, 8'h0C, 32'hDEAD_BEEF, "");
      cyc(1'b0, 1'b1, 1'b1, 8'h10, 32'h0000_0200, "");
      cyc(1'b0, 1'b1, 1'b1, 8'h04, 32'hFFFF_FFFF, "");
      rd(8'h0C, "R9 shadow unaffected by write");
      rd(8'h08, "R9 sec unaffected by writes");
      rd(8'h04, "R9 unmapped read zero");
      rd(8'h14, "R9 unmapped read zero high");
      rd(8'h10, "R9 ms unaffected by write");

      cyc(1'b0, 1'b1, 1'b1, 8'h08, 32'hFFFF_FFFF, "");
      ticks(999);
      rd(8'h08, "R10 sec at all ones");
      ticks(1);
      rd(8'h08, "R10 sec wrapped to zero");
      rd(8'h10, "R10 ms after wrap");
      rd(8'h0C, "R6 shadow unchanged by wrap");

      for (int i = 0; i < 4; i++) begin
         cyc(1'b1, 1'b1, 1'b0, 8'h10, '0, "R5 pair ms");
         cyc(1'b1, 1'b1, 1'b0, 8'h0C, '0, "R5 pair shadow");
      end

      cyc(1'b0, 1'b0, 1'b0, '0, '0, "");
      cyc(1'b0, 1'b0, 1'b0, '0, '0, "");
      check(exp_q.size() == 0, "R4 every read answered", 32'(exp_q.size()), '0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule